// File: doc/BRIEF.md
# Seconds Counter with Alarm Compare

This block keeps a 32-bit count of elapsed seconds behind a small word-addressed register interface. A one-pulse-per-second tick, produced outside the block, advances the count while the counter is running. Software can load a new count at any time. It can read the live value back, and it can program one alarm compare value. When the count steps onto that value, a sticky status bit is set. The interrupt output reflects that status unless the interrupt is masked.

A build parameter chooses the storage form. With the parameter off, the count and the alarm are plain binary. With it on, software writes the preload and alarm words as Gray code (b ^ (b >> 1)), and the live readback returns Gray code. The counter then moves from one Gray code to the next, so exactly one stored bit changes per second. Register writes take effect on the clock edge that follows the write strobe. Reads are combinational from the address.

Top module: `sec_alarm_ctr`

## Requirements
- R1: After reset the following hold: the control word reads 0, the mask word (0x20) reads 1, the status word (0x30) reads 0, the live time (0x34) reads 0, and irq_o is 0.
- R2: The control register at 0x00 stores only three bits: bit 0 is alarm enable, bit 8 is the oscillator-select flag and bit 12 is counter run. All other bits read 0.
- R3: A write to 0x04 loads the stored count with the written word, and the new count is visible at 0x34 in the following cycle. If a tick arrives in the same cycle as the load, the load wins.
- R4: The count advances one second per tick only while run (bit 12) is 1. With run at 0 the count holds. After 2^32-1 the next step gives 0.
- R5: With Gray storage, each tick moves the stored count to the Gray code of its binary value plus one, so exactly one bit changes per step.
- R6: The alarm word at 0x08 reads back as written. Status bit 0 at 0x30 sets after a tick on which the count steps to a value equal to the alarm word while alarm enable is 1. A tick that coincides with a load never sets it, and with alarm enable at 0 the status never sets.
- R7: irq_o equals status AND NOT mask, where the mask is bit 0 at 0x20.
- R8: Writing a word with bit 0 set to 0x24 clears the status. Writing a word with bit 0 clear does nothing. If a clear and a new match fall in the same cycle, the status stays set.
- R9: Reads of 0x04, 0x24 and of any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per second |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 8 | Byte address of the register word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Alarm interrupt |

## Verification
Two instances, one with binary storage and one with Gray storage, receive the same stimulus. Because the same preload and alarm words are written to both, one word stands for different seconds values in each form, and a match that lands on the wrong tick shows up as a difference between the instances. The patterns cover these cases:
- ticks with run off and with run on, which separate holding from counting;
- a preload near the top of the range, which exposes a faulty wrap;
- a tick in the same cycle as a load, and a clear in the same cycle as a match, which settle the two priority rules;
- a match with alarm enable at 0, and a masked status, which show that enable and mask gate different points.

// File: rtl/sac_pkg.sv
package sac_pkg;
  localparam int unsigned OFS_CTRL  = 'h00;
  localparam int unsigned OFS_LOAD  = 'h04;
  localparam int unsigned OFS_ALARM = 'h08;
  localparam int unsigned OFS_MASK  = 'h20;
  localparam int unsigned OFS_CLR   = 'h24;
  localparam int unsigned OFS_STAT  = 'h30;
  localparam int unsigned OFS_LIVE  = 'h34;

  localparam int unsigned BIT_ALM_EN  = 0;
  localparam int unsigned BIT_OSC_SEL = 8;
  localparam int unsigned BIT_RUN     = 12;
endpackage

// File: rtl/sac_regs.sv
module sac_regs
  import sac_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic          alm_en_o,
  output logic          osc_sel_o,
  output logic          run_o,
  output logic          mask_o,
  output logic [W-1:0]  alarm_o,
  output logic          load_o,
  output logic          clr_o
);
  logic sel_ctrl, sel_alarm, sel_mask;

  assign sel_ctrl  = wr_i && (addr_i == AW'(OFS_CTRL));
  assign sel_alarm = wr_i && (addr_i == AW'(OFS_ALARM));
  assign sel_mask  = wr_i && (addr_i == AW'(OFS_MASK));
  assign load_o    = wr_i && (addr_i == AW'(OFS_LOAD));
  assign clr_o     = wr_i && (addr_i == AW'(OFS_CLR)) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_en_o  <= 1'b0;
      osc_sel_o <= 1'b0;
      run_o     <= 1'b0;
      mask_o    <= 1'b1;
      alarm_o   <= '0;
    end else begin
      if (sel_ctrl) begin
        alm_en_o  <= wdata_i[BIT_ALM_EN];
        osc_sel_o <= wdata_i[BIT_OSC_SEL];
        run_o     <= wdata_i[BIT_RUN];
      end
      if (sel_mask)  mask_o  <= wdata_i[0];
      if (sel_alarm) alarm_o <= wdata_i;
    end
  end

  // R2: run flag follows the written bit
  a_r2_run_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ctrl |=> run_o == $past(wdata_i[BIT_RUN]));
  // R7: mask write lands in the next cycle
  a_r7_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_mask |=> mask_o == $past(wdata_i[0]));
endmodule

// File: rtl/sac_count.sv
module sac_count #(
  parameter int W    = 32,
  parameter bit GRAY = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] step_o,
  output logic         adv_o
);
  function automatic logic [W-1:0] g2b(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0] cnt_q;

  generate
    if (GRAY) begin : g_gray
      logic [W-1:0] bin_nxt;
      assign bin_nxt = g2b(cnt_q) + 1'b1;
      assign step_o  = bin_nxt ^ (bin_nxt >> 1);
    end else begin : g_bin
      assign step_o = cnt_q + 1'b1;
    end
  endgenerate

  assign adv_o = run_i && tick_i && !load_i;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (adv_o)  cnt_q <= step_o;
  end

  // R4: idle count holds
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !(run_i && tick_i) |=> $stable(cnt_q));
  // R3: load takes priority
  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
  generate
    if (GRAY) begin : g_chk
      // R5: one stored bit flips per step
      a_r5_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adv_o |=> $countones(cnt_q ^ $past(cnt_q)) == 1);
    end
  endgenerate
endmodule

// File: rtl/sac_irq.sv
module sac_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic status_o,
  output logic irq_o
);
  logic status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      status_q <= 1'b0;
    else if (match_i) status_q <= 1'b1;  // match beats clear
    else if (clr_i)   status_q <= 1'b0;
  end

  assign status_o = status_q;
  assign irq_o    = status_q && !mask_i;

  // R6: match sets status
  a_r6_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |=> status_q);
  // R8: clear without match drops status
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !match_i |=> !status_q);
  // R6: status only rises on a match
  a_r6_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_i |=> !$rose(status_q));
endmodule

// File: rtl/sec_alarm_ctr.sv
module sec_alarm_ctr
  import sac_pkg::*;
#(
  parameter int W    = 32,
  parameter int AW   = 8,
  parameter bit GRAY = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic          irq_o
);
  logic         alm_en, osc_sel, run, mask, load, clr, adv, status, match;
  logic [W-1:0] alarm, cnt, step;

  sac_regs #(.W(W), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .alm_en_o(alm_en), .osc_sel_o(osc_sel), .run_o(run), .mask_o(mask),
    .alarm_o(alarm), .load_o(load), .clr_o(clr)
  );

  sac_count #(.W(W), .GRAY(GRAY)) u_count (
    .clk_i, .rst_ni, .run_i(run), .tick_i, .load_i(load), .load_val_i(wdata_i),
    .cnt_o(cnt), .step_o(step), .adv_o(adv)
  );

  assign match = adv && alm_en && (step == alarm);

  sac_irq u_irq (
    .clk_i, .rst_ni, .match_i(match), .clr_i(clr), .mask_i(mask),
    .status_o(status), .irq_o
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(OFS_CTRL)) begin
      rdata_o[BIT_ALM_EN]  = alm_en;
      rdata_o[BIT_OSC_SEL] = osc_sel;
      rdata_o[BIT_RUN]     = run;
    end else if (addr_i == AW'(OFS_ALARM)) rdata_o = alarm;
    else if (addr_i == AW'(OFS_MASK))      rdata_o[0] = mask;
    else if (addr_i == AW'(OFS_STAT))      rdata_o[0] = status;
    else if (addr_i == AW'(OFS_LIVE))      rdata_o = cnt;
  end

  // R7: masked status never reaches the pin
  a_r7_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask |-> !irq_o);
endmodule

// File: tb/sim_sec_alarm_ctr.sv
module sim_sec_alarm_ctr;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        tick_i = 1'b0, wr_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rd0, rd1;
  logic        irq0, irq1;

  always #5 clk_i = ~clk_i;

  sec_alarm_ctr #(.GRAY(1'b1)) u0 (.clk_i, .rst_ni, .tick_i, .wr_i, .addr_i,
    .wdata_i, .rdata_o(rd0), .irq_o(irq0));
  sec_alarm_ctr #(.GRAY(1'b0)) u1 (.clk_i, .rst_ni, .tick_i, .wr_i, .addr_i,
    .wdata_i, .rdata_o(rd1), .irq_o(irq1));

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model, index 0 = Gray, 1 = binary
  logic [31:0] m_bin [2];
  logic [31:0] m_alm [2];
  bit          m_st  [2];
  bit          m_aen, m_osc, m_run, m_mask;

  function automatic logic [31:0] enc(int i, logic [31:0] b);
    return (i == 0) ? (b ^ (b >> 1)) : b;
  endfunction

  function automatic logic [31:0] dec(int i, logic [31:0] s);
    logic [31:0] b;
    if (i != 0) return s;
    b = '0;
    for (int k = 31; k >= 0; k--) b[k] = s[k] ^ ((k == 31) ? 1'b0 : b[k+1]);
    return b;
  endfunction

  function automatic logic [31:0] exp_rd(int i, logic [7:0] a);
    case (a)
      8'h00: return {19'd0, m_run, 3'd0, m_osc, 7'd0, m_aen};
      8'h08: return m_alm[i];
      8'h20: return {31'd0, m_mask};
      8'h30: return {31'd0, m_st[i]};
      8'h34: return enc(i, m_bin[i]);
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 2; i++) begin m_bin[i] = 0; m_alm[i] = 0; m_st[i] = 0; end
      m_aen = 0; m_osc = 0; m_run = 0; m_mask = 1;
    end else begin
      bit ld, cl, mt;
      ld = wr_i && addr_i == 8'h04;
      cl = wr_i && addr_i == 8'h24 && wdata_i[0];
      for (int i = 0; i < 2; i++) begin
        mt = tick_i && m_run && m_aen && !ld && (enc(i, m_bin[i] + 1) == m_alm[i]);
        if (mt) m_st[i] = 1; else if (cl) m_st[i] = 0;
        if (ld) m_bin[i] = dec(i, wdata_i);
        else if (tick_i && m_run) m_bin[i] = m_bin[i] + 1;
        if (wr_i && addr_i == 8'h08) m_alm[i] = wdata_i;
      end
      if (wr_i && addr_i == 8'h00) begin
        m_aen = wdata_i[0]; m_osc = wdata_i[8]; m_run = wdata_i[12];
      end
      if (wr_i && addr_i == 8'h20) m_mask = wdata_i[0];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R7: interrupt compared every clock
  always @(negedge clk_i) if (rst_ni && !done) begin
    chk("R7 irq gray", {31'd0, irq0}, {31'd0, m_st[0] & ~m_mask});
    chk("R7 irq bin",  {31'd0, irq1}, {31'd0, m_st[1] & ~m_mask});
  end

  task automatic drive(bit w, logic [7:0] a, logic [31:0] d, bit t);
    @(negedge clk_i);
    wr_i = w; addr_i = a; wdata_i = d; tick_i = t;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d); drive(1, a, d, 0); endtask
  task automatic tick(int n); for (int k = 0; k < n; k++) drive(0, 8'h00, 0, 1); endtask

  task automatic rd(string tag, logic [7:0] a);
    drive(0, a, 0, 0);
    #1;
    chk(tag, rd0, exp_rd(0, a));
    chk(tag, rd1, exp_rd(1, a));
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    rd("R1 ctrl", 8'h00); chk("R1 ctrl const", rd0, 0);
    rd("R1 mask", 8'h20); chk("R1 mask const", rd1, 1);
    rd("R1 stat", 8'h30); rd("R1 live", 8'h34);
    chk("R1 irq", {31'd0, irq0 | irq1}, 0);
    // R2 control bits
    wr(8'h00, 32'hFFFF_FFFF); rd("R2 ctrl all", 8'h00);
    chk("R2 ctrl const", rd1, 32'h0000_1101);
    wr(8'h00, 32'h0000_0000);
    // R4 hold while stopped
    wr(8'h04, 32'h10); tick(3); rd("R4 stopped", 8'h34);
    chk("R4 stopped const", rd1, 32'h10);
    // R4 / R5 counting
    wr(8'h00, 32'h1000); wr(8'h04, 0); tick(5);
    rd("R4 count", 8'h34); chk("R4 bin 5", rd1, 5); chk("R5 gray 5", rd0, 32'h7);
    // R4 wrap
    wr(8'h04, 32'hFFFF_FFFE); tick(2); rd("R4 wrap", 8'h34);
    chk("R4 wrap bin", rd1, 0);
    tick(1); rd("R4 after wrap", 8'h34);
    // R3 load beats tick
    drive(1, 8'h04, 32'h55, 1); rd("R3 load wins", 8'h34);
    chk("R3 load const", rd1, 32'h55);
    // R6 alarm match with enable
    wr(8'h04, 0); wr(8'h08, 3); rd("R6 alarm rb", 8'h08);
    wr(8'h20, 0); wr(8'h00, 32'h1001); tick(4);
    rd("R6 status", 8'h30); chk("R6 set bin", rd1, 1); chk("R6 set gray", rd0, 1);
    chk("R7 irq on", {31'd0, irq1}, 1);
    // R7 mask hides status
    wr(8'h20, 1); rd("R7 masked stat", 8'h30); chk("R7 masked", {31'd0, irq1}, 0);
    wr(8'h20, 0);
    // R8 clear with bit0 = 0 ignored, then real clear
    wr(8'h24, 32'hFFFF_FFFE); rd("R8 no clear", 8'h30); chk("R8 kept", rd1, 1);
    wr(8'h24, 1); rd("R8 cleared", 8'h30); chk("R8 cleared const", rd1, 0);
    // R8 clear and match in the same cycle
    wr(8'h04, 0); wr(8'h08, 1); tick(1); rd("R8 pre", 8'h30);
    wr(8'h04, 0); drive(1, 8'h24, 1, 1); rd("R8 match wins", 8'h30);
    chk("R8 match wins const", rd1, 1);
    wr(8'h24, 1);
    // R6 no set with enable 0
    wr(8'h00, 32'h1000); wr(8'h04, 0); tick(2);
    rd("R6 disabled", 8'h30); chk("R6 disabled const", rd1, 0);
    // R6 no set when load coincides with tick
    wr(8'h00, 32'h1001); wr(8'h04, 0); drive(1, 8'h04, 0, 1);
    rd("R6 load no match", 8'h30); chk("R6 load const", rd1, 0);
    // R9 write-only and unmapped reads
    rd("R9 load rd", 8'h04); chk("R9 load const", rd0, 0);
    rd("R9 clr rd", 8'h24); rd("R9 unmapped", 8'h10); chk("R9 unmapped const", rd1, 0);
    tick(3); rd("R4 final", 8'h34);
    finish_run();
  end
endmodule